// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block times the multiplexed external memory bus of an 8-bit microcontroller core. It runs on the oscillator clock and divides it into machine cycles of twelve phases, which are six states of two clocks each. For every machine cycle it decides what the bus does: an internal code fetch, an external code fetch, or an external data read or write with a 16-bit or 8-bit address. It then drives the address-latch strobe (ALE), the program-store strobe (PSEN, active low), the read and write strobes, the shared low-address/data port and the high-address port.

The core presents its request for the next machine cycle before that cycle begins. The block samples the request once, on the clock edge that closes the current cycle, and keeps it for all twelve phases. A single auxiliary control bit that software can write turns off the free-running ALE pulses. That control is ignored while code comes from external memory. A reset-pin filter asserts the core reset only after the pin has been high for two full machine cycles.

Top module: `bus_strobe_seq`

## Requirements
- R1: `phase_o` counts 0 to 11 and wraps to 0, one step per clock, while the core reset is not asserted.
- R2: In a cycle with no data access, and with ALE enabled or code fetched externally, `ale_o` is 1 exactly in phases 1, 2, 7 and 8. That is two pulses per machine cycle, one sixth of the clock rate.
- R3: In an external code cycle with no data access, `psen_no` is 0 exactly in phases 4, 5, 10 and 11. In an internal code cycle, `psen_no` stays 1.
- R4: A cycle fetches code externally when `ea_ni` is 0, or when `pc_i` is greater than or equal to `CODE_SIZE` (16384 by default).
- R5: In a data-access cycle (`xdata_i`=1), `ale_o` pulses only in phases 1 and 2, so the second pulse is dropped. `psen_no` stays 1 for all twelve phases, so both fetch strobes are skipped.
- R6: In a data read (`xwr_i`=0), `rd_no` is 0 in phases 4 to 10. In a data write (`xwr_i`=1), `wr_no` is 0 in phases 4 to 10, and `ad_o` carries `xwdata_i` with `ad_oe_o`=1 in phases 3 to 11. Outside these phases both strobes are 1.
- R7: In external code and data cycles, the low port drives the low address byte whenever ALE is high. In an external code cycle that byte is `pc_i[7:0]` in phases 1-2 and `(pc_i+1)[7:0]` in phases 7-8. In a data cycle it is `xaddr_i[7:0]`. Apart from the write window of R6, `ad_oe_o` is 0 in every other phase.
- R8: `ha_o` carries `pc_i[15:8]` in phases 0-5 and `(pc_i+1)[15:8]` in phases 6-11 of an external code cycle. It carries `xaddr_i[15:8]` in a data cycle with `xwide_i`=1. It carries `p2_latch_i` in a data cycle with `xwide_i`=0 and in an internal code cycle.
- R9: A write with `sfr_we_i`=1 and `sfr_addr_i`=8'h8E loads `sfr_bit0_i` into the ALE-disable bit. A write to any other address leaves the bit unchanged. While the bit is 1, an internal code cycle with no data access holds `ale_o`=1 and `ale_weak_o`=1 for all phases. `ale_weak_o` is 0 in every other case.
- R10: The ALE-disable bit has no effect in external code cycles, which follow R2. In data cycles, which follow R5, ALE still pulses and `ale_weak_o` stays 0.
- R11: `core_rst_o` becomes 1 after `rst_pin_i` has been sampled high on 24 consecutive clock edges, and not after 23. While `core_rst_o` is 1, `phase_o`=0, `ale_o`=0, `psen_no`=`rd_no`=`wr_no`=1 and `ad_oe_o`=0. The core reset also clears the ALE-disable bit.
- R12: The cycle request (`ea_ni`, `pc_i`, `xdata_i`, `xwr_i`, `xwide_i`, `xaddr_i`, `xwdata_i`, and the ALE-disable bit including a write made on that same edge) is sampled on the edge that leaves phase 11. Changes to these inputs later in the cycle have no effect until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_pin_i | input | 1 | Reset pin level, filtered to two machine cycles |
| ea_ni | input | 1 | External access, low forces external code fetch |
| pc_i | input | 16 | Code address of the first fetch of the next cycle |
| xdata_i | input | 1 | Next cycle is an external data access |
| xwr_i | input | 1 | Data access is a write |
| xwide_i | input | 1 | Data access uses a 16-bit address |
| xaddr_i | input | 16 | Data address |
| xwdata_i | input | 8 | Write data |
| p2_latch_i | input | 8 | Contents of the high-port latch register |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register write address |
| sfr_bit0_i | input | 1 | Bit 0 of the register write data |
| phase_o | output | 4 | Current phase 0..11 of the machine cycle |
| core_rst_o | output | 1 | Filtered core reset |
| ale_o | output | 1 | Address latch strobe |
| ale_weak_o | output | 1 | ALE held high by the weak pull-up only |
| psen_no | output | 1 | Program store strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Low address / data port value |
| ad_oe_o | output | 1 | Low port drive enable |
| ha_o | output | 8 | High address port value |

## Verification
The ALE-disable bit and an access that must override it can fall in the same machine cycle. This happens when the bit is set and the cycle is also an external code fetch or a data access. The sweep writes the bit on the very edge that samples each such request, across every combination of access kind, external-access level and code address. For each phase, ALE and the weak-high flag are compared with the override rules, which take precedence over the disable. A second overlap is that a request changing during a cycle coincides with the strobes already running. This is provoked by scrambling the request inputs right after phase 0 and requiring that the whole cycle still follow the sampled request.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam int AW      = 16;
  localparam int DW      = 8;
  localparam int STATES  = 6;
  localparam int HALVES  = 2;
  localparam int MCYC    = STATES * HALVES;
  localparam int PH_W    = $clog2(MCYC);
  localparam logic [7:0] AUX_ADDR = 8'h8E;

  typedef struct packed {
    logic          ext;
    logic          data;
    logic          wr;
    logic          wide;
    logic          ale_off;
    logic [AW-1:0] pc;
    logic [AW-1:0] xaddr;
    logic [DW-1:0] wdata;
  } cyc_t;
endpackage

// File: rtl/bus_rst_filter.sv
module bus_rst_filter #(
  parameter int LIMIT = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic core_rst_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!pin_i)    cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign core_rst_o = (cnt_q == LIM);

  p_rst_needs_pin_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> $past(pin_i));
endmodule

// File: rtl/bus_cycle_ctr.sv
module bus_cycle_ctr
  import bus_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            core_rst_i,
  input  cyc_t            ctl_nxt_i,
  output logic [PH_W-1:0] phase_o,
  output cyc_t            ctl_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(MCYC - 1);

  logic [PH_W-1:0] phase_q;
  cyc_t            ctl_q;
  logic            wrap;

  assign wrap = core_rst_i || (phase_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      ctl_q   <= '0;
    end else if (wrap) begin
      phase_q <= '0;
      ctl_q   <= ctl_nxt_i;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign ctl_o   = ctl_q;

  p_phase_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_i && phase_q == LAST) |=> (phase_q == '0));
  p_phase_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_i && phase_q != LAST) |=> (phase_q == PH_W'($past(phase_q) + 1'b1)));
  p_ctl_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_i && phase_q != LAST) |=> $stable(ctl_q));
endmodule

// File: rtl/bus_strobe_dec.sv
module bus_strobe_dec
  import bus_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            core_rst_i,
  input  logic [PH_W-1:0] phase_i,
  input  cyc_t            ctl_i,
  input  logic [DW-1:0]   p2_i,
  output logic            ale_o,
  output logic            ale_weak_o,
  output logic            psen_no,
  output logic            rd_no,
  output logic            wr_no,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  output logic [DW-1:0]   ha_o
);
  logic          first_half, ale_slot, ale_first, psen_slot, strobe_win, wdrive;
  logic [AW-1:0] pc_next;

  always_comb begin
    first_half = (phase_i < PH_W'(MCYC / 2));
    ale_first  = (phase_i == PH_W'(1)) || (phase_i == PH_W'(2));
    ale_slot   = ale_first || (phase_i == PH_W'(7)) || (phase_i == PH_W'(8));
    psen_slot  = (phase_i == PH_W'(4))  || (phase_i == PH_W'(5)) ||
                 (phase_i == PH_W'(10)) || (phase_i == PH_W'(11));
    strobe_win = (phase_i >= PH_W'(4)) && (phase_i <= PH_W'(10));
    wdrive     = (phase_i >= PH_W'(3));
    pc_next    = ctl_i.pc + 1'b1;
  end

  always_comb begin
    ale_o      = 1'b0;
    ale_weak_o = 1'b0;
    psen_no    = 1'b1;
    rd_no      = 1'b1;
    wr_no      = 1'b1;
    ad_o       = '0;
    ad_oe_o    = 1'b0;
    ha_o       = p2_i;
    if (core_rst_i) begin
      ha_o = p2_i;
    end else if (ctl_i.data) begin
      // one ALE for the data address, fetch strobes skipped
      ale_o   = ale_first;
      rd_no   = !(!ctl_i.wr && strobe_win);
      wr_no   = !(ctl_i.wr && strobe_win);
      ad_oe_o = ale_first || (ctl_i.wr && wdrive);
      if (ale_first)     ad_o = ctl_i.xaddr[DW-1:0];
      else if (ctl_i.wr) ad_o = ctl_i.wdata;
      ha_o = ctl_i.wide ? ctl_i.xaddr[AW-1:DW] : p2_i;
    end else if (ctl_i.ext) begin
      ale_o   = ale_slot;
      psen_no = !psen_slot;
      ad_oe_o = ale_slot;
      if (ale_slot) ad_o = first_half ? ctl_i.pc[DW-1:0] : pc_next[DW-1:0];
      ha_o = first_half ? ctl_i.pc[AW-1:DW] : pc_next[AW-1:DW];
    end else if (ctl_i.ale_off) begin
      ale_o      = 1'b1;
      ale_weak_o = 1'b1;
    end else begin
      ale_o = ale_slot;
    end
  end

  p_psen_internal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.ext && !core_rst_i) |-> psen_no);
  p_psen_skip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.data && !core_rst_i) |-> psen_no);
  p_addr_on_ale_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && (ctl_i.ext || ctl_i.data)) |-> ad_oe_o);
  p_rdwr_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> (psen_no && !ale_o && (rd_no != wr_no)));
  p_weak_only_int_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_weak_o |-> (ale_o && !ctl_i.ext && !ctl_i.data));
endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
  import bus_seq_pkg::*;
#(
  parameter int CODE_SIZE = 16384,
  parameter int RST_MCYC  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rst_pin_i,
  input  logic            ea_ni,
  input  logic [AW-1:0]   pc_i,
  input  logic            xdata_i,
  input  logic            xwr_i,
  input  logic            xwide_i,
  input  logic [AW-1:0]   xaddr_i,
  input  logic [DW-1:0]   xwdata_i,
  input  logic [DW-1:0]   p2_latch_i,
  input  logic            sfr_we_i,
  input  logic [7:0]      sfr_addr_i,
  input  logic            sfr_bit0_i,
  output logic [PH_W-1:0] phase_o,
  output logic            core_rst_o,
  output logic            ale_o,
  output logic            ale_weak_o,
  output logic            psen_no,
  output logic            rd_no,
  output logic            wr_no,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  output logic [DW-1:0]   ha_o
);
  localparam logic [AW:0] CODE_LIM = (AW+1)'(CODE_SIZE);

  logic core_rst, ale_off_q, ale_off_d;
  cyc_t ctl_nxt, ctl;

  bus_rst_filter #(.LIMIT(RST_MCYC * MCYC)) i_rst_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (rst_pin_i),
    .core_rst_o (core_rst)
  );

  always_comb begin
    ale_off_d = ale_off_q;
    if (core_rst)                                     ale_off_d = 1'b0;
    else if (sfr_we_i && (sfr_addr_i == AUX_ADDR))    ale_off_d = sfr_bit0_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ale_off_q <= 1'b0;
    else         ale_off_q <= ale_off_d;
  end

  always_comb begin
    ctl_nxt.ext     = !ea_ni || ({1'b0, pc_i} >= CODE_LIM);
    ctl_nxt.data    = xdata_i;
    ctl_nxt.wr      = xwr_i;
    ctl_nxt.wide    = xwide_i;
    ctl_nxt.ale_off = ale_off_d;
    ctl_nxt.pc      = pc_i;
    ctl_nxt.xaddr   = xaddr_i;
    ctl_nxt.wdata   = xwdata_i;
  end

  bus_cycle_ctr i_cycle_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .core_rst_i (core_rst),
    .ctl_nxt_i  (ctl_nxt),
    .phase_o    (phase_o),
    .ctl_o      (ctl)
  );

  bus_strobe_dec i_strobe_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .core_rst_i (core_rst),
    .phase_i    (phase_o),
    .ctl_i      (ctl),
    .p2_i       (p2_latch_i),
    .ale_o      (ale_o),
    .ale_weak_o (ale_weak_o),
    .psen_no    (psen_no),
    .rd_no      (rd_no),
    .wr_no      (wr_no),
    .ad_o       (ad_o),
    .ad_oe_o    (ad_oe_o),
    .ha_o       (ha_o)
  );

  assign core_rst_o = core_rst;

  p_aux_cleared_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst |=> !ale_off_q);
  p_idle_in_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst |-> (!ale_o && psen_no && rd_no && wr_no && !ad_oe_o));
endmodule

// File: tb/test_bus_strobe_seq.sv
`timescale 1ns/1ps
module test_bus_strobe_seq;
  localparam int CODE_SIZE = 16384;

  logic clk = 1'b0, rst_ni = 1'b0, rst_pin = 1'b0;
  logic ea_n = 1'b1, xdata = 1'b0, xwr = 1'b0, xwide = 1'b0;
  logic [15:0] pc = '0, xaddr = '0;
  logic [7:0] wdata = '0, p2 = 8'h00, sfr_addr = '0;
  logic sfr_we = 1'b0, sfr_bit = 1'b0;
  logic [3:0] phase;
  logic core_rst, ale, ale_weak, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0] ad, ha;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_ale_off = 0;

  always #2.5 clk = ~clk;

  bus_strobe_seq #(.CODE_SIZE(CODE_SIZE)) i_bus_strobe_seq (
    .clk_i(clk), .rst_ni(rst_ni), .rst_pin_i(rst_pin), .ea_ni(ea_n), .pc_i(pc),
    .xdata_i(xdata), .xwr_i(xwr), .xwide_i(xwide), .xaddr_i(xaddr), .xwdata_i(wdata),
    .p2_latch_i(p2), .sfr_we_i(sfr_we), .sfr_addr_i(sfr_addr), .sfr_bit0_i(sfr_bit),
    .phase_o(phase), .core_rst_o(core_rst), .ale_o(ale), .ale_weak_o(ale_weak),
    .psen_no(psen_n), .rd_no(rd_n), .wr_no(wr_n), .ad_o(ad), .ad_oe_o(ad_oe), .ha_o(ha));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic wait_ph11();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (phase == 4'd11) break;
    end
  endtask

  // called at a phase-11 negedge; ends at the next phase-11 negedge
  task automatic run_cycle(input bit e_n, input logic [15:0] a_pc, input int kind,
                           input bit do_we, input logic [7:0] w_addr, input bit w_bit,
                           input bit scramble);
    bit ext, dat, w, wd, ao, first, slot, sfirst;
    logic [15:0] xa, pcn;
    logic [7:0] wd8, e_ha;
    string tg_ale, tg_ps;
    ea_n = e_n; pc = a_pc;
    xdata = (kind != 0); xwr = (kind >= 3); xwide = (kind == 2) || (kind == 4);
    xaddr = a_pc ^ 16'h5A3C; wdata = a_pc[7:0] ^ 8'hC3; p2 = a_pc[15:8] ^ 8'h96;
    sfr_we = do_we; sfr_addr = w_addr; sfr_bit = w_bit;
    if (do_we && w_addr == 8'h8E) m_ale_off = w_bit;
    ext = !e_n || (a_pc >= 16'(CODE_SIZE)); dat = xdata; w = xwr; wd = xwide; ao = m_ale_off;
    xa = xaddr; wd8 = wdata; pcn = a_pc + 16'd1;
    tg_ale = dat ? (ao ? "R10" : "R5") : (ext ? (ao ? "R10" : "R2") : (ao ? "R9" : "R2"));
    tg_ps  = dat ? "R5" : ((e_n && ext) ? "R4" : "R3");
    for (int p = 0; p < 12; p++) begin
      bit e_ale, e_weak, e_ps, e_rd, e_wr, e_oe;
      logic [7:0] e_ad;
      @(negedge clk);
      sfr_we = 1'b0;
      if (scramble && p == 0) begin
        ea_n = ~e_n; pc = ~a_pc; xdata = ~dat; xwr = ~w; xwide = ~wd;
        xaddr = ~xa; wdata = ~wd8;
        tg_ale = "R12"; tg_ps = "R12";
      end
      first = (p < 6); slot = (p == 1 || p == 2 || p == 7 || p == 8); sfirst = (p == 1 || p == 2);
      e_ale = 0; e_weak = 0; e_ps = 1; e_rd = 1; e_wr = 1; e_oe = 0; e_ad = 0; e_ha = p2;
      if (dat) begin
        e_ale = sfirst; e_rd = !(!w && p >= 4 && p <= 10); e_wr = !(w && p >= 4 && p <= 10);
        e_oe = sfirst || (w && p >= 3); e_ad = sfirst ? xa[7:0] : wd8;
        e_ha = wd ? xa[15:8] : p2;
      end else if (ext) begin
        e_ale = slot; e_ps = !(p == 4 || p == 5 || p == 10 || p == 11); e_oe = slot;
        e_ad = first ? a_pc[7:0] : pcn[7:0]; e_ha = first ? a_pc[15:8] : pcn[15:8];
      end else begin
        e_ale = ao ? 1'b1 : slot; e_weak = ao;
      end
      chk(phase == 4'(p), scramble ? "R12 phase" : "R1 phase", phase, p);
      chk(ale == e_ale, tg_ale, ale, e_ale);
      chk(ale_weak == e_weak, scramble ? "R12" : "R9 weak", ale_weak, e_weak);
      chk(psen_n == e_ps, tg_ps, psen_n, e_ps);
      chk(rd_n == e_rd, "R6 rd", rd_n, e_rd);
      chk(wr_n == e_wr, "R6 wr", wr_n, e_wr);
      chk(ad_oe == e_oe, "R7 oe", ad_oe, e_oe);
      if (e_oe) chk(ad == e_ad, dat && !sfirst ? "R6 wdata" : "R7 addr", ad, e_ad);
      chk(ha == e_ha, "R8 high addr", ha, e_ha);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(phase == 0, "R1 reset phase", phase, 0);
    chk(core_rst == 0, "R11 reset state", core_rst, 0);
    chk(psen_n && rd_n && wr_n && !ad_oe, "R11 idle strobes", {psen_n, rd_n, wr_n, ad_oe}, 4'b1110);
    rst_ni = 1'b1;
    wait_ph11();
    // sweep: ea level x code address x access kind x ALE-disable bit
    for (int e = 0; e < 2; e++)
      for (int ps = 0; ps < 4; ps++)
        for (int k = 0; k < 5; k++)
          for (int a = 0; a < 2; a++) begin
            logic [15:0] v;
            case (ps)
              0: v = 16'h0012;
              1: v = 16'h3FFF;
              2: v = 16'h4000;
              default: v = 16'hC0FF;
            endcase
            run_cycle(e[0], v, k, 1'b1, 8'h8E, a[0], 1'b0);
          end
    // write to a neighbouring address must not set the bit (R9)
    run_cycle(1'b1, 16'h0100, 0, 1'b1, 8'h8E, 1'b0, 1'b0);
    run_cycle(1'b1, 16'h0100, 0, 1'b1, 8'h8F, 1'b1, 1'b0);
    // mid-cycle input changes ignored (R12)
    run_cycle(1'b0, 16'h2345, 0, 1'b0, 8'h00, 1'b0, 1'b1);
    run_cycle(1'b1, 16'h1111, 3, 1'b0, 8'h00, 1'b0, 1'b1);
    run_cycle(1'b1, 16'h0222, 0, 1'b1, 8'h8E, 1'b1, 1'b1);
    run_cycle(1'b1, 16'h0222, 0, 1'b0, 8'h00, 1'b0, 1'b0);
    // short reset pulse: no core reset, disable bit kept (R11)
    rst_pin = 1'b1;
    for (int i = 0; i < 23; i++) begin
      @(negedge clk);
      if (core_rst) chk(1'b0, "R11 early reset", core_rst, 0);
    end
    chk(core_rst == 0, "R11 23 edges", core_rst, 0);
    rst_pin = 1'b0;
    wait_ph11();
    run_cycle(1'b1, 16'h0300, 0, 1'b0, 8'h00, 1'b0, 1'b0);
    // full reset
    rst_pin = 1'b1;
    repeat (23) @(negedge clk);
    chk(core_rst == 0, "R11 23 edges", core_rst, 0);
    @(negedge clk);
    chk(core_rst == 1, "R11 24 edges", core_rst, 1);
    ea_n = 1'b0; pc = 16'h0040; xdata = 1'b0;
    repeat (5) begin
      @(negedge clk);
      chk(phase == 0 && !ale && psen_n && rd_n && wr_n && !ad_oe, "R11 idle in reset",
          {phase, ale, psen_n, rd_n, wr_n, ad_oe}, 9'b0000_01110);
    end
    rst_pin = 1'b0;
    m_ale_off = 1'b0;
    wait_ph11();
    run_cycle(1'b1, 16'h0300, 0, 1'b0, 8'h00, 1'b0, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule